// File: doc/BRIEF.md
# Floating-Point Control and Status Register File

This block keeps the one 32-bit control and status word of a floating-point unit. Coprocessor control accesses reach that word through five aliased selectors. Selector 0 is a fixed identification value. Selector 25 is a packed view of the condition codes. Selector 26 is an exceptions view holding cause and sticky flags. Selector 28 is an enables view that also carries the rounding mode and the flush-to-zero bit. Selector 31 is the whole word. Each read is returned as a 64-bit value, sign-extended from 32 bits.

The arithmetic unit reports a per-operation exception status vector. From that vector the block rebuilds the cause field and accumulates the sticky flags. When an enabled cause is present, it raises a one-cycle exception request. Some control writes also test the new word and may raise the request. The full word is available as an output, so the datapath can read the rounding mode and the flush-to-zero setting.

Word layout:

| Bits | Field |
|------|-------|
| 1:0 | rounding mode |
| 6:2 | sticky flags, in the order inexact, underflow, overflow, divide-by-zero, invalid |
| 11:7 | enables, same order |
| 17:12 | cause: bits 16:12 in the same order, bit 17 unimplemented |
| 22:18 | reserved, always zero |
| 23 | condition code 0 |
| 24 | flush-to-zero |
| 31:25 | condition codes 1 to 7 |

Top module: `fpu_csr_file`

## Requirements
- R1: After reset the word is zero, `fpe_req` is low, and selector 31 reads zero.
- R2: Selector 0 reads the parameter `IMPL_ID`, sign-extended. A write to selector 0 leaves the word unchanged and raises no request.
- R3: Selector 25 reads {word[31:25], word[23]} in bits 7:0, with zeros above. A write to it loads data bits 7:1 into word bits 31:25 and data bit 0 into word bit 23. All other bits are kept, and the write never raises a request.
- R4: Selector 26 reads the word masked to bits 17:12 and 6:2. A write to it replaces only those bits.
- R5: Selector 28 reads bits 11:7 and 1:0 of the word, with the flush-to-zero bit (word bit 24) copied into bit 2. A write to it sets bit 24 from data bit 2 and loads bits 11:7 and 1:0 from the data. It keeps bits 31:25, 23, 17:12 and 6:2.
- R6: A write to selector 31 loads the whole word, with bits 22:18 forced to zero. Those bits read as zero at all times.
- R7: After a write to selector 26, 28 or 31, `fpe_req` is high for the following cycle when the new word has (bits 16:12 AND bits 11:7) nonzero, or has bit 17 set.
- R8: A status update replaces the cause field. Any of status bits NUM_INV-1:0 sets cause bit 16 (invalid). Bit NUM_INV sets bit 15 (divide-by-zero), NUM_INV+1 sets bit 14 (overflow), NUM_INV+2 sets bit 13 (underflow) and NUM_INV+3 sets bit 12 (inexact). Bit 17 becomes zero.
- R9: A status update raises `fpe_req` in the next cycle when a new cause bit meets its enable. It ORs the new cause bits 16:12 into the sticky flags 6:2, which an update never clears.
- R10: A status update with an all-zero vector only clears the cause field and raises no request.
- R11: Reads of any other selector return zero. Only bits 31:0 of the write data are used.
- R12: When a write and a status update arrive in the same cycle, the write is performed and the update is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | control register write strobe |
| wr_sel | input | 5 | selector written |
| wr_data | input | 64 | write value, low 32 bits used |
| rd_sel | input | 5 | selector read |
| rd_data | output | 64 | sign-extended read value (combinational) |
| upd_en | input | 1 | arithmetic status update strobe |
| upd_status | input | NUM_INV+4 | per-operation exception conditions |
| csr_word | output | 32 | current status word |
| fpe_req | output | 1 | one-cycle exception request |

## Verification
The hardest state to reach is a word whose unimplemented cause bit is set while all enables are clear. No arithmetic update can set that bit, so the stimulus first plants it with an exceptions-view write. The test then confirms three things. A later condition-code write leaves the bit alone and raises no request. A full exceptions-view write still traps because of that bit alone. The next arithmetic update clears it. A further case changes only the enables while an unenabled cause is already waiting, and the bench checks that this write alone produces the request.

// File: rtl/fpu_csr_file.sv
module fpu_csr_file #(
  parameter logic [31:0] IMPL_ID = 32'h8003_0501,
  parameter int NUM_INV = 8,
  parameter int SEL_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [63:0]          wr_data,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [63:0]          rd_data,
  input  logic                 upd_en,
  input  logic [NUM_INV+3:0]   upd_status,
  output logic [31:0]          csr_word,
  output logic                 fpe_req
);

  localparam logic [31:0] LIVE_M  = 32'hFF83_FFFF;
  localparam logic [31:0] CC_M    = 32'hFE80_0000;
  localparam logic [31:0] FS_M    = 32'h0100_0000;
  localparam logic [31:0] CAUSE_M = 32'h0003_F000;
  localparam logic [31:0] FLAG_M  = 32'h0000_007C;
  localparam logic [31:0] EN_M    = 32'h0000_0F80;
  localparam logic [31:0] RM_M    = 32'h0000_0003;
  localparam logic [SEL_W-1:0] SEL_ID = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_CC = SEL_W'(25);
  localparam logic [SEL_W-1:0] SEL_EX = SEL_W'(26);
  localparam logic [SEL_W-1:0] SEL_EN = SEL_W'(28);
  localparam logic [SEL_W-1:0] SEL_ST = SEL_W'(31);

  logic [31:0] word_q, word_d, wv, rv;
  logic        trap_d;
  logic [5:0]  new_cause;

  function automatic logic must_trap(input logic [31:0] w);
    return (|(w[16:12] & w[11:7])) | w[17];
  endfunction

  assign wv = wr_data[31:0];

  assign new_cause = {1'b0,
                      |upd_status[NUM_INV-1:0],
                      upd_status[NUM_INV],
                      upd_status[NUM_INV+1],
                      upd_status[NUM_INV+2],
                      upd_status[NUM_INV+3]};

  always_comb begin
    word_d = word_q;
    trap_d = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        SEL_CC: word_d = (word_q & ~CC_M) | {wv[7:1], 1'b0, wv[0], 23'b0};
        SEL_EX: begin
          word_d = (word_q & ~(CAUSE_M | FLAG_M)) | (wv & (CAUSE_M | FLAG_M));
          trap_d = must_trap(word_d);
        end
        SEL_EN: begin
          word_d = (word_q & (CC_M | CAUSE_M | FLAG_M)) | (wv & (EN_M | RM_M))
                 | (wv[2] ? FS_M : 32'h0);
          trap_d = must_trap(word_d);
        end
        SEL_ST: begin
          word_d = wv & LIVE_M;
          trap_d = must_trap(word_d);
        end
        default: word_d = word_q;
      endcase
    end else if (upd_en) begin
      word_d = (word_q & ~CAUSE_M) | {14'b0, new_cause, 12'b0};
      trap_d = |(new_cause[4:0] & word_q[11:7]);
      word_d[6:2] = word_q[6:2] | new_cause[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      fpe_req <= 1'b0;
    end else begin
      word_q  <= word_d;
      fpe_req <= trap_d;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_ID:  rv = IMPL_ID;
      SEL_CC:  rv = {24'b0, word_q[31:25], word_q[23]};
      SEL_EX:  rv = word_q & (CAUSE_M | FLAG_M);
      SEL_EN:  rv = (word_q & (EN_M | RM_M)) | {29'b0, word_q[24], 2'b0};
      SEL_ST:  rv = word_q;
      default: rv = '0;
    endcase
  end

  assign rd_data  = {{32{rv[31]}}, rv};
  assign csr_word = word_q;

endmodule

// File: rtl/fpu_csr_file_chk.sv
module fpu_csr_file_chk #(
  parameter int STW = 12,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic             upd_en,
  input logic [STW-1:0]   upd_status,
  input logic [63:0]      rd_data,
  input logic [31:0]      csr_word,
  input logic             fpe_req
);

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_word[22:18] == 5'b0);

  assert_sign_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:32] == {32{rd_data[31]}});

  assert_id_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(0)) |=> ($stable(csr_word) && !fpe_req));

  assert_cc_write_no_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(25)) |=> (!fpe_req && csr_word[22:0] == $past(csr_word[22:0])
                                         && csr_word[24] == $past(csr_word[24])));

  assert_clean_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && upd_en && upd_status == '0) |=> (!fpe_req && csr_word[17:12] == 6'b0
                                                 && csr_word[31:18] == $past(csr_word[31:18])
                                                 && csr_word[11:0] == $past(csr_word[11:0])));

  assert_sticky_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && upd_en) |=> ((csr_word[6:2] & $past(csr_word[6:2])) == $past(csr_word[6:2])));

  assert_no_unimpl_from_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && upd_en) |=> !csr_word[17]);

  assert_quiet_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_en) |=> (!fpe_req && $stable(csr_word)));

endmodule

bind fpu_csr_file fpu_csr_file_chk #(.STW(NUM_INV + 4), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .upd_en(upd_en),
  .upd_status(upd_status), .rd_data(rd_data), .csr_word(csr_word), .fpe_req(fpe_req));

// File: tb/sim_fpu_csr_file.sv
module sim_fpu_csr_file;
  localparam logic [31:0] ID = 32'h8003_0501;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, upd_en = 0;
  logic [4:0]  wr_sel = 0, rd_sel = 0;
  logic [63:0] wr_data = 0, rd_data;
  logic [11:0] upd_status = 0;
  logic [31:0] csr_word;
  logic        fpe_req;
  int total = 0, bad = 0;
  bit done = 0;

  fpu_csr_file #(.IMPL_ID(ID), .NUM_INV(8), .SEL_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .upd_en(upd_en), .upd_status(upd_status),
    .csr_word(csr_word), .fpe_req(fpe_req));

  always #5 clk = ~clk;

  typedef struct packed {
    logic        upd;
    logic [4:0]  sel;
    logic [31:0] data;
    logic [11:0] st;
    logic [31:0] exp_word;
    logic        exp_req;
    logic [3:0]  req_id;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd31, 32'hFFFF_FFFF, 12'h000, 32'hFF83_FFFF, 1'b1, 4'd6},
    '{1'b0, 5'd31, 32'h0000_0000, 12'h000, 32'h0000_0000, 1'b0, 4'd6},
    '{1'b0, 5'd28, 32'h0000_0F85, 12'h000, 32'h0100_0F81, 1'b0, 4'd5},
    '{1'b1, 5'd0,  32'h0,         12'h800, 32'h0100_1F85, 1'b1, 4'd9},
    '{1'b1, 5'd0,  32'h0,         12'h000, 32'h0100_0F85, 1'b0, 4'd10},
    '{1'b1, 5'd0,  32'h0,         12'h003, 32'h0101_0FC5, 1'b1, 4'd8},
    '{1'b0, 5'd28, 32'h0000_0000, 12'h000, 32'h0001_0044, 1'b0, 4'd5},
    '{1'b1, 5'd0,  32'h0,         12'h100, 32'h0000_8064, 1'b0, 4'd8},
    '{1'b0, 5'd26, 32'h0002_0000, 12'h000, 32'h0002_0000, 1'b1, 4'd7},
    '{1'b0, 5'd25, 32'h0000_00FF, 12'h000, 32'hFE82_0000, 1'b0, 4'd3},
    '{1'b0, 5'd26, 32'hFFFF_FFFF, 12'h000, 32'hFE83_F07C, 1'b1, 4'd4},
    '{1'b1, 5'd0,  32'h0,         12'hE00, 32'hFE80_707C, 1'b0, 4'd8},
    '{1'b0, 5'd0,  32'hFFFF_FFFF, 12'h000, 32'hFE80_707C, 1'b0, 4'd2},
    '{1'b0, 5'd28, 32'h0000_0100, 12'h000, 32'hFE80_717C, 1'b1, 4'd7}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [4:0] s, input logic [63:0] d,
                      input logic u, input logic [11:0] st);
    wr_en = w; wr_sel = s; wr_data = d; upd_en = u; upd_status = st;
    @(posedge clk); @(negedge clk);
    wr_en = 0; upd_en = 0; wr_sel = 0; wr_data = 0; upd_status = 0;
  endtask

  task automatic rd(input logic [4:0] s, input string tag, input logic [63:0] exp);
    rd_sel = s; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 word", {32'b0, csr_word}, 64'h0);
    check("R1 req", {63'b0, fpe_req}, 64'h0);
    rd(5'd31, "R1 read31", 64'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      step(!VEC[i].upd, VEC[i].sel, {32'hDEAD_BEEF, VEC[i].data}, VEC[i].upd, VEC[i].st);
      check($sformatf("R%0d vec%0d word", VEC[i].req_id, i), {32'b0, csr_word}, {32'b0, VEC[i].exp_word});
      check($sformatf("R%0d vec%0d req", VEC[i].req_id, i), {63'b0, fpe_req}, {63'b0, VEC[i].exp_req});
    end

    // R7 request lasts one cycle
    @(negedge clk);
    check("R7 pulse drop", {63'b0, fpe_req}, 64'h0);

    // read views: R2 R3 R4 R5 R11
    step(1, 5'd31, 64'h0000_0000_A5FF_FFFF, 0, 0);
    rd(5'd0,  "R2 id read", 64'hFFFF_FFFF_8003_0501);
    rd(5'd25, "R3 cc read", 64'h0000_0000_0000_00A5);
    rd(5'd26, "R4 exc read", 64'h0000_0000_0003_F07C);
    rd(5'd28, "R5 en read", 64'h0000_0000_0000_0F87);
    rd(5'd31, "R11 sign-extended read", 64'hFFFF_FFFF_A583_FFFF);
    rd(5'd7,  "R11 unused read", 64'h0);

    // R11 upper data ignored
    step(1, 5'd31, 64'hFFFF_FFFF_0000_0000, 0, 0);
    check("R11 upper data", {32'b0, csr_word}, 64'h0);

    // R12 write beats update
    step(1, 5'd25, 64'h1, 1, 12'h800);
    check("R12 word", {32'b0, csr_word}, 64'h0000_0000_0080_0000);
    check("R12 req", {63'b0, fpe_req}, 64'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule